// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a MAC byte stream into host memory through a ring of 16-byte descriptors. Each descriptor holds a status word (offset 0), a tag word (offset 4), a low buffer address (offset 8) and a high buffer address (offset 12). When a frame starts, the engine reads the status word and the low buffer address of the current descriptor. If the device owns that descriptor, the engine stores the frame bytes in the buffer. At the end of the frame it writes back a status word that carries the length and the error flags, and that returns ownership to the host.

The ring has no length register. After a descriptor whose end-of-ring flag is set, the engine goes back to the ring base. Otherwise it steps 16 bytes forward. If a frame arrives while the host still owns the current descriptor, the engine drops the frame, counts it as missed and stays on the same descriptor. Two sticky interrupt status bits record good and failed receives. The host clears them with write-one-to-clear strobes.

The memory is a single-port, 32-bit, little-endian bus. Reads return data one cycle after the request.

Top module: `rxr_engine`

## Requirements
- R1: While reset is held, cur_desc_addr equals {ring_base, 8'h00}, irq_status and miss_count are zero, and mem_req is low.
- R2: On rx_start the engine reads the status word at cur_desc_addr and the low buffer address at cur_desc_addr+8. If status bit 31 (ownership) is 1, each received byte n is written to buffer address + n. The write is a single-byte-lane write: the lane given by address bits 1:0 is enabled and lane 0 is the lowest byte.
- R3: The write-back status word has bit 31 cleared, bit 30 copied from the fetched status, bits 29 and 28 set, and bits 12:0 equal to the number of bytes received, which includes the 4-byte check sequence.
- R4: Write-back bit 19 copies rx_crc_err taken with rx_end. Bit 20 is set when the length is below MIN_LEN (64). Bit 22 is set when the length is above MAX_LEN (1536). Bit 21 is the OR of those three flags and truncation. All other bits from 27 down to 13 are zero.
- R5: The buffer size is status bits 12:0 of the fetched descriptor. Bytes past that size are not written, and the frame is reported with bit 21 set.
- R6: After a write-back, cur_desc_addr moves 16 bytes forward. If bit 30 (end-of-ring) of the fetched status was set, it returns to the ring base instead.
- R7: A write-back with bit 21 clear sets irq_status bit 0. A write-back with bit 21 set sets bit 1. Both bits stay set until the matching irq_clr bit is pulsed. Clearing one bit leaves the other bit unchanged.
- R8: A frame that finds status bit 31 at 0 causes no memory write. It leaves cur_desc_addr unchanged, raises miss_count by one and sets no irq_status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W-8 | Ring base address bits above bit 7 (256-byte aligned) |
| rx_start | input | 1 | Pulse at frame start |
| rx_valid | input | 1 | rx_data holds a frame byte |
| rx_data | input | 8 | Frame byte |
| rx_end | input | 1 | Pulse at frame end |
| rx_crc_err | input | 1 | Check-sequence error, qualified by rx_end |
| irq_clr | input | 2 | Write-one-to-clear strobes for irq_status |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| cur_desc_addr | output | ADDR_W | Address of the current descriptor |
| irq_status | output | 2 | Bit 0 good receive, bit 1 receive error |
| miss_count | output | MISS_W | Saturating count of frames dropped for lack of a descriptor |

## Verification
The assertions rely on the following behaviour of the inputs:
- ring_base is held constant.
- rx_start is pulsed only while the engine is idle.
- No byte arrives within four cycles of rx_start.
- rx_end comes on a cycle without a byte.
- The next frame starts only after the write-back cycle.
- The memory returns read data exactly one cycle after the request.

The bench respects all of this. It waits five cycles after each start, sends the bytes back to back, pulses rx_end on its own cycle and leaves three idle cycles before any host access or new frame. The host writes descriptors only while the engine is idle, so its accesses never collide with the engine's.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int LEN_W  = 13;
    localparam int OWN_B  = 31;
    localparam int EOR_B  = 30;
    localparam int FS_B   = 29;
    localparam int LS_B   = 28;
    localparam int RWT_B  = 22;
    localparam int RES_B  = 21;
    localparam int RUNT_B = 20;
    localparam int CRC_B  = 19;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ST,
        S_RD_BA,
        S_RD_WAIT,
        S_RECV,
        S_WB,
        S_DROP
    } rx_state_e;

    typedef struct packed {
        logic crc;
        logic runt;
        logic rwt;
        logic trunc;
    } rx_err_t;

    function automatic logic [31:0] pack_wb(logic eor, rx_err_t e, logic [LEN_W-1:0] len);
        logic [31:0] w;
        w            = '0;
        w[EOR_B]     = eor;
        w[FS_B]      = 1'b1;
        w[LS_B]      = 1'b1;
        w[RWT_B]     = e.rwt;
        w[RUNT_B]    = e.runt;
        w[CRC_B]     = e.crc;
        w[RES_B]     = |e;
        w[LEN_W-1:0] = len;
        return w;
    endfunction

endpackage

// File: rtl/rxr_len_counter.sv
module rxr_len_counter #(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [LEN_W-1:0] buf_size,
    output logic [LEN_W-1:0] count,
    output logic             in_buf,
    output logic             trunc
);
    assign in_buf = count < buf_size;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            trunc <= 1'b0;
        end else if (inc) begin
            if (count != {LEN_W{1'b1}})
                count <= count + 1'b1;
            if (!in_buf)
                trunc <= 1'b1;
        end
    end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-9:0] base_hi,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    always_ff @(posedge clk) begin
        if (rst)
            addr <= {base_hi, 8'h00};
        else if (advance)
            addr <= wrap ? {base_hi, 8'h00} : addr + STEP;
    end
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq #(
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_good,
    input  logic              set_err,
    input  logic [1:0]        clr,
    input  logic              miss_inc,
    output logic [1:0]        status,
    output logic [MISS_W-1:0] miss_count
);
    logic [1:0] set_vec;
    assign set_vec = {set_err, set_good};

    always_ff @(posedge clk) begin
        if (rst) begin
            status     <= '0;
            miss_count <= '0;
        end else begin
            status <= (status & ~clr) | set_vec;
            if (miss_inc && miss_count != {MISS_W{1'b1}})
                miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1536,
    parameter int MISS_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-9:0] ring_base,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic              rx_crc_err,
    input  logic [1:0]        irq_clr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] cur_desc_addr,
    output logic [1:0]        irq_status,
    output logic [MISS_W-1:0] miss_count
);
    localparam int DESC_BYTES = 16;
    localparam logic [ADDR_W-1:0] BA_OFS = ADDR_W'(8);

    rx_state_e         state;
    logic              eor_q;
    logic              crc_q;
    logic [LEN_W-1:0]  bsize_q;
    logic [ADDR_W-1:0] baddr_q;
    logic [LEN_W-1:0]  len;
    logic              in_buf;
    logic              trunc;
    logic              cnt_clr, cnt_inc, ptr_adv, miss_inc;
    logic              err_any;
    rx_err_t           err;
    logic [ADDR_W-1:0] byte_addr;

    assign byte_addr = baddr_q + ADDR_W'(len);

    always_comb begin
        err.crc   = crc_q;
        err.runt  = len < LEN_W'(MIN_LEN);
        err.rwt   = len > LEN_W'(MAX_LEN);
        err.trunc = trunc;
    end
    assign err_any = |err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            eor_q   <= 1'b0;
            crc_q   <= 1'b0;
            bsize_q <= '0;
            baddr_q <= '0;
        end else begin
            case (state)
                S_IDLE:    if (rx_start) state <= S_RD_ST;
                S_RD_ST:   state <= S_RD_BA;
                S_RD_BA: begin
                    eor_q   <= mem_rdata[EOR_B];
                    bsize_q <= mem_rdata[LEN_W-1:0];
                    state   <= mem_rdata[OWN_B] ? S_RD_WAIT : S_DROP;
                end
                S_RD_WAIT: begin
                    baddr_q <= mem_rdata;
                    state   <= S_RECV;
                end
                S_RECV: begin
                    if (rx_end) begin
                        crc_q <= rx_crc_err;
                        state <= S_WB;
                    end
                end
                S_WB:      state <= S_IDLE;
                S_DROP:    if (rx_end) state <= S_IDLE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = 4'h0;
        mem_wdata = '0;
        case (state)
            S_RD_ST: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc_addr;
            end
            S_RD_BA: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc_addr + BA_OFS;
            end
            S_RECV: begin
                if (rx_valid && in_buf) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = {byte_addr[ADDR_W-1:2], 2'b00};
                    mem_be    = 4'b0001 << byte_addr[1:0];
                    mem_wdata = {4{rx_data}};
                end
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_desc_addr;
                mem_be    = 4'hF;
                mem_wdata = pack_wb(eor_q, err, len);
            end
            default: ;
        endcase
    end

    assign cnt_clr  = (state == S_RD_ST);
    assign cnt_inc  = (state == S_RECV) && rx_valid;
    assign ptr_adv  = (state == S_WB);
    assign miss_inc = (state == S_RD_BA) && !mem_rdata[OWN_B];

    rxr_len_counter #(.LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .buf_size (bsize_q),
        .count    (len),
        .in_buf   (in_buf),
        .trunc    (trunc)
    );

    rxr_ring_ptr #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .base_hi (ring_base),
        .advance (ptr_adv),
        .wrap    (eor_q),
        .addr    (cur_desc_addr)
    );

    rxr_irq #(.MISS_W(MISS_W)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .set_good   (ptr_adv && !err_any),
        .set_err    (ptr_adv && err_any),
        .clr        (irq_clr),
        .miss_inc   (miss_inc),
        .status     (irq_status),
        .miss_count (miss_count)
    );
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-9:0] ring_base,
    input logic              mem_req,
    input logic              mem_we,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic [ADDR_W-1:0] cur_desc_addr,
    input logic [1:0]        irq_status,
    input logic [MISS_W-1:0] miss_count
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(16);

    // R1: no memory traffic under reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |-> !mem_req);

    // R2: a write uses exactly one byte lane or a whole word
    assert_lane_shape_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1 || mem_be == 4'hF));

    // R3: full-word writes never hand ownership to the device
    assert_wb_owner_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_be == 4'hF) |-> !mem_wdata[31]);

    // R6: pointer moves only by one descriptor or back to the base
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_desc_addr) |->
            (cur_desc_addr == $past(cur_desc_addr) + STEP ||
             cur_desc_addr == {ring_base, 8'h00}));

    // R7: one write-back never raises both interrupt bits together
    assert_irq_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !($rose(irq_status[0]) && $rose(irq_status[1])));

    // R8: missed count grows by one and the pointer holds meanwhile
    assert_miss_step_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(miss_count) |->
            (miss_count == $past(miss_count) + MISS_W'(1) && $stable(cur_desc_addr)));
endmodule

bind rxr_engine rxr_engine_chk #(.ADDR_W(ADDR_W), .MISS_W(MISS_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ring_base     (ring_base),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_be        (mem_be),
    .mem_wdata     (mem_wdata),
    .cur_desc_addr (cur_desc_addr),
    .irq_status    (irq_status),
    .miss_count    (miss_count)
);

// File: tb/sim_rxr_engine.sv
module sim_rxr_engine;
    localparam int ADDR_W = 32;
    localparam int MISS_W = 16;
    localparam int MEM_W  = 4096;
    localparam int NV     = 9;
    localparam logic [31:0] RING = 32'h0000_0100;

    localparam int VEC_LEN [NV] = '{70, 40, 100, 300, 80, 64, 1600, 1536, 63};
    localparam int VEC_BSZ [NV] = '{256, 256, 256, 128, 256, 256, 2000, 2000, 256};
    localparam bit VEC_CRC [NV] = '{0, 0, 1, 0, 0, 0, 0, 0, 0};
    localparam bit VEC_OWN [NV] = '{1, 1, 1, 1, 0, 1, 1, 1, 1};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-9:0] ring_base = RING[ADDR_W-1:8];
    logic              rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0, rx_crc_err = 1'b0;
    logic [7:0]        rx_data = '0;
    logic [1:0]        irq_clr = '0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [3:0]        mem_be;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata;
    logic [ADDR_W-1:0] cur_desc_addr;
    logic [1:0]        irq_status;
    logic [MISS_W-1:0] miss_count;

    logic              host_we = 1'b0;
    logic [31:0]       host_addr = '0, host_wdata = '0;
    logic [31:0]       mem [0:MEM_W-1];
    int                wr_cnt = 0;
    int                checks = 0, failures = 0;

    always #2 clk = ~clk;

    rxr_engine #(.ADDR_W(ADDR_W), .MISS_W(MISS_W)) u0 (
        .clk(clk), .rst(rst), .ring_base(ring_base),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_end(rx_end), .rx_crc_err(rx_crc_err), .irq_clr(irq_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cur_desc_addr(cur_desc_addr), .irq_status(irq_status),
        .miss_count(miss_count)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < MEM_W; k++) mem[k] <= 32'hEEEE_EEEE;
        end else begin
            if (host_we) mem[host_addr[13:2]] <= host_wdata;
            if (mem_req && mem_we) begin
                wr_cnt <= wr_cnt + 1;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
        end
        mem_rdata <= mem[mem_addr[13:2]];
    end

    function automatic logic [7:0] pat(int f, int i);
        return 8'((f * 37 + i * 5 + 3) & 255);
    endfunction

    function automatic logic [7:0] get_byte(logic [31:0] a);
        return mem[a[13:2]][8*a[1:0] +: 8];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic send_frame(int f, int len, bit crc);
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        repeat (5) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1; rx_data = pat(f, i);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_end = 1'b1; rx_crc_err = crc;
        @(negedge clk);
        rx_end = 1'b0; rx_crc_err = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_status(int len, int bsz, bit crc, bit eor);
        bit runt, rwt, tr, res;
        runt = len < 64; rwt = len > 1536; tr = len > bsz;
        res  = runt | rwt | tr | crc;
        return (32'(eor) << 30) | (32'd1 << 29) | (32'd1 << 28) | (32'(rwt) << 22) |
               (32'(res) << 21) | (32'(runt) << 20) | (32'(crc) << 19) | 32'(len);
    endfunction

    task automatic arm(int di, bit own, int bsz);
        logic [31:0] da;
        da = RING + 32'(di * 16);
        host_write(da, (32'(own) << 31) | (32'(di == 3) << 30) | 32'(bsz));
        host_write(da + 8, 32'h1000 + 32'(di * 32'h800));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int di = 0;
        int exp_miss = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ptr", cur_desc_addr, RING);
        check("R1 irq", 32'(irq_status), 0);
        check("R1 miss", 32'(miss_count), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int f = 0; f < NV; f++) begin
            logic [31:0] da, ba, st;
            int w0, bad, n;
            da = RING + 32'(di * 16);
            ba = 32'h1000 + 32'(di * 32'h800);
            arm(di, VEC_OWN[f], VEC_BSZ[f]);
            w0 = wr_cnt;
            send_frame(f, VEC_LEN[f], VEC_CRC[f]);
            if (VEC_OWN[f]) begin
                st = exp_status(VEC_LEN[f], VEC_BSZ[f], VEC_CRC[f], di == 3);
                // R3 R4 status write-back
                check("R3/R4 status", mem[da[13:2]], st);
                check("R7 irq", 32'(irq_status), st[21] ? 32'd2 : 32'd1);
                n = (VEC_LEN[f] < VEC_BSZ[f]) ? VEC_LEN[f] : VEC_BSZ[f];
                bad = 0;
                for (int i = 0; i < n; i++)
                    if (get_byte(ba + 32'(i)) !== pat(f, i)) bad++;
                check("R2 data", 32'(bad), 0);
                // R5 nothing past the buffer
                check("R5 boundary", 32'(get_byte(ba + 32'(VEC_BSZ[f]))), 32'hEE);
                di = (di + 1) % 4;
                // R6 pointer advance or wrap
                check("R6 ptr", cur_desc_addr, RING + 32'(di * 16));
            end else begin
                exp_miss++;
                // R8 dropped frame
                check("R8 no writes", 32'(wr_cnt - w0), 0);
                check("R8 ptr", cur_desc_addr, da);
                check("R8 irq", 32'(irq_status), 0);
                check("R8 desc kept", mem[da[13:2]], 32'(VEC_BSZ[f]) | (32'(di == 3) << 30));
            end
            check("R8 miss", 32'(miss_count), 32'(exp_miss));
            @(negedge clk); irq_clr = 2'b11;
            @(negedge clk); irq_clr = 2'b00;
            check("R7 clear", 32'(irq_status), 0);
        end

        // R7 sticky: good then error without clearing, then partial clear
        arm(di, 1'b1, 256);
        send_frame(20, 90, 1'b0);
        di = (di + 1) % 4;
        arm(di, 1'b1, 256);
        send_frame(21, 90, 1'b1);
        check("R7 sticky both", 32'(irq_status), 3);
        @(negedge clk); irq_clr = 2'b01;
        @(negedge clk); irq_clr = 2'b00;
        check("R7 partial clear", 32'(irq_status), 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule